// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block is the first stage of a 32-bit memory management unit. It divides the virtual space into sixteen 256 MB segments, selected by the top address nibble. Each accepted request is routed four ways. It can pass through untranslated while translation is off, or raise an access fault for a user access above the user window. A kernel access to a segment configured as direct has its top nibble swapped for that segment's base value. Any other request is paged: the block sends the virtual page number and the 8 KB page offset to a page-lookup port and builds the physical address from the page number that comes back.

Three configuration registers are written through a plain address/data/write-enable port. Register 0 holds one mode bit per segment in bits [15:0], where 1 means direct and 0 means paged. Register 1 holds the 4-bit bases for segments 0 to 7, and register 2 holds the bases for segments 8 to f. In both, the base of segment s sits at bits [4*(s mod 8)+3 : 4*(s mod 8)]. Requests and results use valid/ready handshakes.

The controller has four states. IDLE accepts a request; it goes to DONE for pass, direct or fault routes, and to LOOKUP for a paged route. LOOKUP offers the lookup request and goes to WAIT_PAGE when the lookup port takes it. WAIT_PAGE goes to DONE when a lookup response arrives. DONE presents the result and returns to IDLE when it is taken.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and lk_req_valid are 0, every segment is paged and every base value is zero.
- R2: With xlat_en low, an accepted request returns rsp_paddr equal to the virtual address with no fault flags, and rsp_valid rises one cycle after acceptance. No lookup is made, and this holds for user accesses too.
- R3: With xlat_en high, a user access whose top nibble is 0xB or above returns rsp_access_fault=1 and rsp_paddr=0 one cycle after acceptance, with no lookup.
- R4: With xlat_en high, a kernel access to a segment whose mode bit is 1 returns {base, vaddr[27:0]} one cycle after acceptance, with no lookup.
- R5: A segment's base is taken from register 2 for segments 8 to f and from register 1 for segments 0 to 7, at bit position 4*(s mod 8).
- R6: A paged request raises lk_req_valid with lk_vpn=vaddr[31:13] and lk_offset=vaddr[12:0], and holds all three steady until lk_req_ready is seen.
- R7: A lookup response with lk_rsp_miss=0 returns rsp_paddr={lk_rsp_ppn, vaddr[12:0]} with no fault flags.
- R8: A lookup response with lk_rsp_miss=1 returns rsp_page_fault=1 and rsp_paddr=0.
- R9: While rsp_valid is high and rsp_ready is low, the result stays unchanged and req_ready stays low. Once the result is taken, the block is back in IDLE.
- R10: A user access below 0xB0000000 is paged even when its segment's mode bit is 1.
- R11: A configuration write to address 3 changes no translation.
- R12: rsp_access_fault and rsp_page_fault are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 mode, 1 low bases, 2 high bases) |
| cfg_wdata | input | 32 | Configuration write data |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 for a user access, 0 for kernel |
| lk_req_valid | output | 1 | Page-lookup request valid |
| lk_req_ready | input | 1 | Page-lookup port takes the request |
| lk_vpn | output | 19 | Virtual page number |
| lk_offset | output | 13 | Page offset |
| lk_rsp_valid | input | 1 | Page-lookup response valid |
| lk_rsp_ppn | input | 19 | Physical page number |
| lk_rsp_miss | input | 1 | No mapping for the page |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | 32 | Physical address |
| rsp_access_fault | output | 1 | User access above the user window |
| rsp_page_fault | output | 1 | Lookup miss |

## Verification
The assertions assume that the lookup port sends a response only while the block waits in WAIT_PAGE. They also assume that configuration is not rewritten while a request is being accepted, because the route is decided from the registers at acceptance. The bench drives one request at a time, raises a lookup response only some cycles after lk_req_ready has been given, and performs register writes only while the block sits in IDLE with req_valid low. Lookup readiness and result readiness are both held off for a cycle so that the hold rules are exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_SEG_W     = 4;
    localparam int DEF_OFF_W     = 13;
    localparam int DEF_USER_SEGS = 11;

    typedef enum logic [1:0] {
        ROUTE_PASS,
        ROUTE_DIRECT,
        ROUTE_PAGED,
        ROUTE_FAULT
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WAIT_PAGE,
        ST_DONE
    } state_e;

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
    parameter int SEG_W  = 4,
    parameter int DATA_W = 32,
    localparam int NSEG     = 1 << SEG_W,
    localparam int NBASE    = (NSEG * SEG_W) / DATA_W,
    localparam int CFG_AW   = $clog2(NBASE + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [NSEG-1:0]       seg_direct,
    output logic [NSEG*SEG_W-1:0] seg_bases
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_direct <= '0;
        end else if (cfg_we && cfg_addr == CFG_AW'(0)) begin
            seg_direct <= cfg_wdata[NSEG-1:0];
        end
    end

    for (genvar r = 0; r < NBASE; r++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_bases[r*DATA_W +: DATA_W] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(r + 1)) begin
                seg_bases[r*DATA_W +: DATA_W] <= cfg_wdata;
            end
        end
    end

    if (NSEG < DATA_W) begin : g_spare
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:NSEG];
    end

endmodule

// File: rtl/seg_route.sv
module seg_route
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_W     = 4,
    parameter int USER_SEGS = 11,
    localparam int NSEG     = 1 << SEG_W,
    localparam int LOW_W    = ADDR_W - SEG_W
) (
    input  logic [ADDR_W-1:0]     vaddr,
    input  logic                  user,
    input  logic                  xlat_en,
    input  logic [NSEG-1:0]       seg_direct,
    input  logic [NSEG*SEG_W-1:0] seg_bases,
    output route_e                route,
    output logic [ADDR_W-1:0]     xlat_paddr
);

    localparam logic [SEG_W-1:0] USER_LIM = SEG_W'(USER_SEGS);

    logic [SEG_W-1:0] base_arr [NSEG];
    logic [SEG_W-1:0] seg;

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign base_arr[g] = seg_bases[g*SEG_W +: SEG_W];
    end

    assign seg = vaddr[ADDR_W-1 -: SEG_W];

    always_comb begin
        if (!xlat_en) begin
            route = ROUTE_PASS;
        end else if (user && seg >= USER_LIM) begin
            route = ROUTE_FAULT;
        end else if (user) begin
            route = ROUTE_PAGED;
        end else if (seg_direct[seg]) begin
            route = ROUTE_DIRECT;
        end else begin
            route = ROUTE_PAGED;
        end
    end

    always_comb begin
        if (route == ROUTE_DIRECT) begin
            xlat_paddr = {base_arr[seg], vaddr[LOW_W-1:0]};
        end else begin
            xlat_paddr = vaddr;
        end
    end

endmodule

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 13,
    localparam int VPN_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  route_e            route,
    input  logic [ADDR_W-1:0] xlat_paddr,
    output logic              lk_req_valid,
    input  logic              lk_req_ready,
    output logic [VPN_W-1:0]  lk_vpn,
    output logic [OFF_W-1:0]  lk_offset,
    input  logic              lk_rsp_valid,
    input  logic [VPN_W-1:0]  lk_rsp_ppn,
    input  logic              lk_rsp_miss,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_access_fault,
    output logic              rsp_page_fault
);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] vaddr_q;
    logic [ADDR_W-1:0] paddr_q;
    logic              af_q, pf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = (route == ROUTE_PAGED) ? ST_LOOKUP : ST_DONE;
            ST_LOOKUP:    if (lk_req_ready) state_d = ST_WAIT_PAGE;
            ST_WAIT_PAGE: if (lk_rsp_valid) state_d = ST_DONE;
            ST_DONE:      if (rsp_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // result datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            paddr_q <= '0;
            af_q    <= 1'b0;
            pf_q    <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            vaddr_q <= req_vaddr;
            pf_q    <= 1'b0;
            af_q    <= (route == ROUTE_FAULT);
            paddr_q <= (route == ROUTE_FAULT) ? '0 : xlat_paddr;
        end else if (state_q == ST_WAIT_PAGE && lk_rsp_valid) begin
            pf_q    <= lk_rsp_miss;
            paddr_q <= lk_rsp_miss ? '0 : {lk_rsp_ppn, vaddr_q[OFF_W-1:0]};
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        lk_req_valid = 1'b0;
        rsp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready    = 1'b1;
            ST_LOOKUP:    lk_req_valid = 1'b1;
            ST_WAIT_PAGE: ;
            ST_DONE:      rsp_valid    = 1'b1;
            default:      ;
        endcase
    end

    assign lk_vpn           = vaddr_q[ADDR_W-1:OFF_W];
    assign lk_offset        = vaddr_q[OFF_W-1:0];
    assign rsp_paddr        = paddr_q;
    assign rsp_access_fault = af_q;
    assign rsp_page_fault   = pf_q;

    assert_lk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_valid && !lk_req_ready |=> lk_req_valid && $stable(lk_vpn) && $stable(lk_offset));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && !req_ready && $stable(rsp_paddr)
                                    && $stable(rsp_access_fault) && $stable(rsp_page_fault));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && lk_rsp_miss && state_q == ST_WAIT_PAGE |=> rsp_valid && rsp_page_fault && rsp_paddr == '0);

    assert_fault_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_access_fault && rsp_page_fault));

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int SEG_W     = DEF_SEG_W,
    parameter int OFF_W     = DEF_OFF_W,
    parameter int USER_SEGS = DEF_USER_SEGS,
    localparam int VPN_W    = ADDR_W - OFF_W,
    localparam int NSEG     = 1 << SEG_W,
    localparam int NBASE    = (NSEG * SEG_W) / ADDR_W,
    localparam int CFG_AW   = $clog2(NBASE + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xlat_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_user,
    output logic              lk_req_valid,
    input  logic              lk_req_ready,
    output logic [VPN_W-1:0]  lk_vpn,
    output logic [OFF_W-1:0]  lk_offset,
    input  logic              lk_rsp_valid,
    input  logic [VPN_W-1:0]  lk_rsp_ppn,
    input  logic              lk_rsp_miss,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_access_fault,
    output logic              rsp_page_fault
);

    logic [NSEG-1:0]       seg_direct;
    logic [NSEG*SEG_W-1:0] seg_bases;
    route_e                route;
    logic [ADDR_W-1:0]     xlat_paddr;

    seg_cfg_regs #(.SEG_W(SEG_W), .DATA_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .seg_direct (seg_direct),
        .seg_bases  (seg_bases)
    );

    seg_route #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .USER_SEGS(USER_SEGS)) u_route (
        .vaddr      (req_vaddr),
        .user       (req_user),
        .xlat_en    (xlat_en),
        .seg_direct (seg_direct),
        .seg_bases  (seg_bases),
        .route      (route),
        .xlat_paddr (xlat_paddr)
    );

    seg_xlate_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_vaddr        (req_vaddr),
        .route            (route),
        .xlat_paddr       (xlat_paddr),
        .lk_req_valid     (lk_req_valid),
        .lk_req_ready     (lk_req_ready),
        .lk_vpn           (lk_vpn),
        .lk_offset        (lk_offset),
        .lk_rsp_valid     (lk_rsp_valid),
        .lk_rsp_ppn       (lk_rsp_ppn),
        .lk_rsp_miss      (lk_rsp_miss),
        .rsp_valid        (rsp_valid),
        .rsp_ready        (rsp_ready),
        .rsp_paddr        (rsp_paddr),
        .rsp_access_fault (rsp_access_fault),
        .rsp_page_fault   (rsp_page_fault)
    );

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !xlat_en
        |=> rsp_valid && rsp_paddr == $past(req_vaddr) && !rsp_access_fault && !rsp_page_fault);

    assert_user_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && xlat_en && req_user
        && req_vaddr[ADDR_W-1 -: SEG_W] >= SEG_W'(USER_SEGS)
        |=> rsp_valid && rsp_access_fault && rsp_paddr == '0);

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        xlat_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        lk_req_valid;
    logic        lk_req_ready = 1'b0;
    logic [18:0] lk_vpn;
    logic [12:0] lk_offset;
    logic        lk_rsp_valid = 1'b0;
    logic [18:0] lk_rsp_ppn = '0;
    logic        lk_rsp_miss = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_access_fault;
    logic        rsp_page_fault;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [3:0]  base_t [16];
    logic [15:0] mode_t;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .xlat_en(xlat_en), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
        .lk_vpn(lk_vpn), .lk_offset(lk_offset), .lk_rsp_valid(lk_rsp_valid),
        .lk_rsp_ppn(lk_rsp_ppn), .lk_rsp_miss(lk_rsp_miss), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_access_fault(rsp_access_fault),
        .rsp_page_fault(rsp_page_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_bases();
        logic [31:0] lo, hi;
        lo = '0; hi = '0;
        for (int s = 0; s < 8; s++)  lo[4*s +: 4] = base_t[s];
        for (int s = 8; s < 16; s++) hi[4*(s-8) +: 4] = base_t[s];
        cfg_write(2'd1, lo);
        cfg_write(2'd2, hi);
    endtask

    // one request with lookup model and result hold check (R6, R9)
    task automatic run_req(input logic [31:0] va, input logic user, input logic en,
                           input logic miss, input logic [18:0] ppn,
                           output logic [31:0] pa, output logic af, output logic pf,
                           output bit saw, output int lat);
        int phase;
        saw = 0; lat = 1; phase = 0;
        @(negedge clk);
        xlat_en = en; req_user = user; req_vaddr = va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && lat < 40) begin
            if (phase == 0 && lk_req_valid) begin
                saw = 1;
                chk("R6 vpn", 32'(lk_vpn), 32'(va[31:13]));
                chk("R6 offset", 32'(lk_offset), 32'(va[12:0]));
                phase = 1;
            end else if (phase == 1) begin
                chk("R6 hold valid", 32'(lk_req_valid), 32'd1);
                chk("R6 hold vpn", 32'(lk_vpn), 32'(va[31:13]));
                lk_req_ready = 1'b1;
                phase = 2;
            end else if (phase == 2) begin
                lk_req_ready = 1'b0;
                phase = 3;
            end else if (phase == 3) begin
                lk_rsp_valid = 1'b1; lk_rsp_ppn = ppn; lk_rsp_miss = miss;
                phase = 4;
            end
            @(negedge clk);
            lat++;
        end
        lk_rsp_valid = 1'b0; lk_req_ready = 1'b0;
        pa = rsp_paddr; af = rsp_access_fault; pf = rsp_page_fault;
        chk("R12 fault exclusive", 32'(af & pf), 32'd0);
        @(negedge clk);
        chk("R9 hold valid", 32'(rsp_valid), 32'd1);
        chk("R9 hold paddr", rsp_paddr, pa);
        chk("R9 busy", 32'(req_ready), 32'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 back to idle", 32'({rsp_valid, req_ready}), 32'b01);
    endtask

    task automatic t_reset();
        logic [31:0] pa; logic af, pf; bit saw; int lat;
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 lk_req_valid", 32'(lk_req_valid), 32'd0);
        run_req(32'hC000_1234, 1'b0, 1'b1, 1'b0, 19'h00042, pa, af, pf, saw, lat);
        chk("R1 all paged", 32'(saw), 32'd1);
        cfg_write(2'd0, 32'h0000_FFFF);
        run_req(32'h4567_89AB, 1'b0, 1'b1, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R1 bases zero", pa, 32'h0567_89AB);
    endtask

    task automatic t_passthrough();
        logic [31:0] pa; logic af, pf; bit saw; int lat;
        run_req(32'hC123_4567, 1'b1, 1'b0, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R2 paddr", pa, 32'hC123_4567);
        chk("R2 latency", 32'(lat), 32'd1);
        chk("R2 no fault/lookup", 32'({af, pf, saw}), 32'd0);
        run_req(32'h0000_1FFF, 1'b0, 1'b0, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R2 paddr low", pa, 32'h0000_1FFF);
    endtask

    task automatic t_direct_and_paged();
        logic [31:0] pa, va; logic af, pf; bit saw; int lat;
        mode_t = 16'hF0A5;
        for (int s = 0; s < 16; s++) base_t[s] = 4'((s * 7 + 3) % 16);
        cfg_write(2'd0, {16'h0, mode_t});
        load_bases();
        for (int s = 0; s < 16; s++) begin
            va = {4'(s), 28'h0ABC_DE0} | 32'(s);
            run_req(va, 1'b0, 1'b1, 1'b0, 19'h01230 + 19'(s), pa, af, pf, saw, lat);
            if (mode_t[s]) begin
                chk("R4 R5 direct paddr", pa, {base_t[s], va[27:0]});
                chk("R4 latency", 32'(lat), 32'd1);
                chk("R4 no lookup", 32'(saw), 32'd0);
            end else begin
                chk("R7 paged paddr", pa, {19'h01230 + 19'(s), va[12:0]});
                chk("R7 no faults", 32'({af, pf}), 32'd0);
            end
        end
    endtask

    task automatic t_user();
        logic [31:0] pa; logic af, pf; bit saw; int lat;
        run_req(32'hB000_0000, 1'b1, 1'b1, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R3 fault at limit", 32'({af, pf, saw}), 32'b100);
        chk("R3 paddr zero", pa, 32'h0);
        chk("R3 latency", 32'(lat), 32'd1);
        run_req(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R3 fault top", 32'({af, saw}), 32'b10);
        run_req(32'hAFFF_FFFF, 1'b1, 1'b1, 1'b0, 19'h7ABCD, pa, af, pf, saw, lat);
        chk("R3 below limit ok", pa, {19'h7ABCD, 13'h1FFF});
        chk("R3 below limit no fault", 32'(af), 32'd0);
        // segment 0 is direct (mode bit 0 set) but user goes paged
        run_req(32'h0000_2005, 1'b1, 1'b1, 1'b0, 19'h00077, pa, af, pf, saw, lat);
        chk("R10 user paged", 32'(saw), 32'd1);
        chk("R10 paddr", pa, {19'h00077, 13'h0005});
    endtask

    task automatic t_miss();
        logic [31:0] pa; logic af, pf; bit saw; int lat;
        run_req(32'h1234_5678, 1'b0, 1'b1, 1'b1, 19'h55555, pa, af, pf, saw, lat);
        chk("R8 page fault", 32'({af, pf}), 32'b01);
        chk("R8 paddr zero", pa, 32'h0);
    endtask

    task automatic t_ignored_write();
        logic [31:0] pa; logic af, pf; bit saw; int lat;
        cfg_write(2'd3, 32'hFFFF_FFFF);
        run_req(32'hC0DE_0001, 1'b0, 1'b1, 1'b0, 19'h0, pa, af, pf, saw, lat);
        chk("R11 direct unchanged", pa, {base_t[12], 28'h0DE_0001});
        run_req(32'h1000_0003, 1'b0, 1'b1, 1'b0, 19'h00011, pa, af, pf, saw, lat);
        chk("R11 paged unchanged", 32'(saw), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_direct_and_paged();
        t_user();
        t_miss();
        t_ignored_write();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule